// File: doc/BRIEF.md
# Sigma-Delta Decimation Filter Chain

This block turns the one-bit stream of a sigma-delta modulator into signed 24-bit samples at 1/256 of the clock rate. A new modulator bit is taken on every clock. The bit passes through three stages in a fixed order. First, a fifth-order cascaded integrator-comb decimator reduces the rate by 32. Second, a short symmetric FIR boosts the upper passband to offset the sinc droop of the first stage, and halves the rate. Third, two half-band FIRs in series each halve the rate again. These last two stages set the final stopband and the width of the transition band.

The input is a free-running stream and can never stall, so the block has no handshake at either edge. `mod_bit` is consumed on every clock. `out_valid` is a one-clock strobe that carries no back-pressure: the consumer must take `out_data` in the cycle the strobe is high. Between strobes, `out_data` holds the last word. The passband gain of the whole chain is exactly one. A stream with a density of ones equal to d settles to (2d-1)·2^23, and this value is clamped to the signed 24-bit range.

The FIR stages pass a one-cycle strobe from one stage to the next. Each stage runs its multiply-accumulate one tap per clock on a single multiplier, and it visits only the taps whose coefficient is nonzero.

Top module: `dcf_decim256`

## Requirements
- R1: Bit value 1 counts as +1 and bit value 0 counts as -1. A stream of all ones settles to 8388607, and a stream of all zeros settles to -8388608.
- R2: Once running, `out_valid` rises exactly once every 256 clocks. Inside the chain, the first-stage strobe repeats every 32 clocks and the droop-corrector strobe repeats every 64 clocks.
- R3: `out_valid` is never high on two clocks in a row. `out_data` changes only on a clock where `out_valid` is high.
- R4: The chain has unity DC gain. A stream that repeats with a period dividing 32 and has a density of ones d settles to (2d-1)·2^23. Pattern 1,1,1,0 gives 4194304, and pattern 1,0,0,0 gives -4194304.
- R5: A zero-mean repeating stream settles to exactly 0. This covers the patterns 1,0 / 1,1,0,0 / 1,1,1,1,0,0,0,0.
- R6: A result of +2^23 or more is clamped to 8388607, and a result below -2^23 is clamped to -8388608.
- R7: One clock into a synchronous reset, `out_valid` is 0 and `out_data` is 0. After the reset is released, no strobe appears for at least 1024 clocks, because every delay line must refill first.
- R8: With no reset in between, a switch from all ones to all zeros brings the output to -8388608 within 16 output words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the modulator bit rate |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator bit, consumed every clock |
| out_valid | output | 1 | One-clock strobe marking a new output word |
| out_data | output | 24 | Signed decimated sample, held between strobes |

## Verification
The spacing assertions take for granted that `mod_bit` is a defined 0 or 1 on every clock and that reset lasts at least one clock. The stimulus keeps within this by driving a known bit on every falling edge from a repeating pattern, and by asserting reset for four clocks. The reset-quiet property also assumes reset is high at the first clock edge, so the bench starts with reset asserted. The stage-level multiply-accumulate relies on inputs arriving at least 32 clocks apart. The fixed phase counter of the first stage guarantees this for any bit stream, so no stimulus can violate it.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  localparam int COEF_W = 13;

  // kind 0: droop corrector, kind 1: short half-band, kind 2: long half-band
  function automatic int fir_len(int kind);
    case (kind)
      0:       return 7;
      1:       return 7;
      default: return 11;
    endcase
  endfunction

  // coefficient sum equals 2**fir_shift(kind) for unity DC gain
  function automatic int fir_shift(int kind);
    case (kind)
      0:       return 10;
      1:       return 5;
      default: return 9;
    endcase
  endfunction

  function automatic int fir_coef(int kind, int i);
    int c;
    c = 0;
    case (kind)
      0: case (i)
           0, 6: c = -8;
           1, 5: c = 24;
           2, 4: c = -96;
           3:    c = 1184;
           default: c = 0;
         endcase
      1: case (i)
           0, 6: c = -1;
           2, 4: c = 9;
           3:    c = 16;
           default: c = 0;
         endcase
      default: case (i)
           0, 10: c = 3;
           2, 8:  c = -25;
           4, 6:  c = 150;
           5:     c = 256;
           default: c = 0;
         endcase
    endcase
    return c;
  endfunction

  function automatic int fir_nnz(int kind);
    int n;
    n = 0;
    for (int i = 0; i < fir_len(kind); i++)
      if (fir_coef(kind, i) != 0) n++;
    return n;
  endfunction

  // position of the slot-th nonzero tap
  function automatic int fir_nz_idx(int kind, int slot);
    int seen;
    int idx;
    seen = 0;
    idx  = 0;
    for (int i = 0; i < fir_len(kind); i++)
      if (fir_coef(kind, i) != 0) begin
        if (seen == slot) idx = i;
        seen++;
      end
    return idx;
  endfunction

endpackage

// File: rtl/dcf_cic.sv
`timescale 1ns/1ps
module dcf_cic #(
  parameter int ORDER = 5,
  parameter int RATE  = 32,
  parameter int W     = 27
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mod_bit,
  output logic                out_vld,
  output logic signed [W-1:0] out_data
);
  localparam int PW = $clog2(RATE);
  localparam int FW = $clog2(ORDER + 1);

  logic signed [W-1:0] integ [ORDER];
  logic signed [W-1:0] x;
  logic [PW-1:0]       ph;
  logic [FW-1:0]       cfill;
  logic                strobe;

  // +1 for a one, -1 for a zero
  assign x      = {{(W-1){~mod_bit}}, 1'b1};
  assign strobe = (ph == PW'(RATE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ORDER; i++) integ[i] <= '0;
      ph <= '0;
    end else begin
      integ[0] <= integ[0] + x;
      for (int i = 1; i < ORDER; i++) integ[i] <= integ[i] + integ[i-1];
      ph <= ph + 1'b1;
    end
  end

  // comb section, evaluated once per decimated sample
  for (genvar i = 0; i < ORDER; i++) begin : g_comb
    logic signed [W-1:0] cin;
    logic signed [W-1:0] dout;
    logic signed [W-1:0] dreg;
    if (i == 0) begin : g_first
      assign cin = integ[ORDER-1];
    end else begin : g_next
      assign cin = g_comb[i-1].dout;
    end
    assign dout = cin - dreg;
    always_ff @(posedge clk) begin
      if (rst)         dreg <= '0;
      else if (strobe) dreg <= cin;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      cfill    <= '0;
    end else begin
      out_vld <= 1'b0;
      if (strobe) begin
        out_data <= g_comb[ORDER-1].dout;
        out_vld  <= (cfill == FW'(ORDER));
        if (cfill != FW'(ORDER)) cfill <= cfill + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dcf_fir_dec2.sv
`timescale 1ns/1ps
module dcf_fir_dec2
  import dcf_pkg::*;
#(
  parameter int KIND = 0,
  parameter int DW   = 28
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_vld,
  output logic signed [DW-1:0] out_data
);
  localparam int NTAP  = fir_len(KIND);
  localparam int SHIFT = fir_shift(KIND);
  localparam int NNZ   = fir_nnz(KIND);
  localparam int KW    = (NNZ > 1) ? $clog2(NNZ) : 1;
  localparam int NSLOT = 1 << KW;
  localparam int FW    = $clog2(NTAP + 1);
  localparam int PW    = DW + COEF_W;
  localparam int AW    = PW + KW;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (SHIFT - 1);
  localparam logic signed [AW-1:0] TOPV = AW'({(DW-1){1'b1}});
  localparam logic signed [AW-1:0] BOTV = ~TOPV;

  logic signed [DW-1:0]     dly   [NTAP];
  logic signed [DW-1:0]     tap_x [NSLOT];
  logic signed [COEF_W-1:0] tap_c [NSLOT];

  // only nonzero taps occupy multiply slots
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    if (s < NNZ) begin : g_used
      localparam int IDX = fir_nz_idx(KIND, s);
      assign tap_x[s] = dly[IDX];
      assign tap_c[s] = COEF_W'(fir_coef(KIND, IDX));
    end else begin : g_pad
      assign tap_x[s] = '0;
      assign tap_c[s] = '0;
    end
  end

  logic                 phase;
  logic                 busy;
  logic                 done;
  logic                 arm;
  logic [FW-1:0]        fill;
  logic [KW-1:0]        k;
  logic signed [AW-1:0] acc;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] rnd;
  logic signed [DW-1:0] res;

  assign prod = tap_x[k] * tap_c[k];

  always_comb begin
    rnd = (acc + HALF) >>> SHIFT;
    if (rnd > TOPV)      res = TOPV[DW-1:0];
    else if (rnd < BOTV) res = BOTV[DW-1:0];
    else                 res = rnd[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTAP; i++) dly[i] <= '0;
      phase    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      arm      <= 1'b0;
      fill     <= '0;
      k        <= '0;
      acc      <= '0;
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= done & arm;
      done    <= 1'b0;
      if (done && arm) out_data <= res;
      if (in_vld) begin
        dly[0] <= in_data;
        for (int i = 1; i < NTAP; i++) dly[i] <= dly[i-1];
        phase <= ~phase;
        if (fill != FW'(NTAP)) fill <= fill + 1'b1;
        if (phase) begin
          busy <= 1'b1;
          k    <= '0;
          acc  <= '0;
          arm  <= (fill >= FW'(NTAP - 1));
        end
      end
      if (busy) begin
        acc <= acc + AW'(prod);
        k   <= k + 1'b1;
        if (k == KW'(NNZ - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dcf_out_round.sv
`timescale 1ns/1ps
module dcf_out_round #(
  parameter int IW = 28,
  parameter int OW = 24,
  parameter int SH = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [IW-1:0] in_data,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_data
);
  localparam int XW = IW + 1;
  localparam logic signed [XW-1:0] HALF = XW'(1) <<< (SH - 1);
  localparam logic signed [XW-1:0] TOPV = XW'({(OW-1){1'b1}});
  localparam logic signed [XW-1:0] BOTV = ~TOPV;

  logic signed [XW-1:0] sh;
  logic signed [OW-1:0] sat;

  always_comb begin
    sh = (XW'(in_data) + HALF) >>> SH;
    if (sh > TOPV)      sat = TOPV[OW-1:0];
    else if (sh < BOTV) sat = BOTV[OW-1:0];
    else                sat = sh[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_data <= sat;
    end
  end
endmodule

// File: rtl/dcf_decim256.sv
`timescale 1ns/1ps
module dcf_decim256
  import dcf_pkg::*;
#(
  parameter int CIC_ORDER = 5,
  parameter int CIC_RATE  = 32,
  parameter int OUT_W     = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mod_bit,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int NFIR   = 3;
  localparam int GROWTH = CIC_ORDER * $clog2(CIC_RATE);
  localparam int CIC_W  = GROWTH + 2;
  localparam int DW     = CIC_W + 1;
  localparam int OSH    = GROWTH + 1 - OUT_W;

  logic [NFIR:0]          s_vld;
  logic signed [DW-1:0]   s_data [NFIR+1];
  logic signed [CIC_W-1:0] cic_data;

  dcf_cic #(
    .ORDER (CIC_ORDER),
    .RATE  (CIC_RATE),
    .W     (CIC_W)
  ) u_cic (
    .clk      (clk),
    .rst      (rst),
    .mod_bit  (mod_bit),
    .out_vld  (s_vld[0]),
    .out_data (cic_data)
  );

  assign s_data[0] = DW'(cic_data);

  // stage j uses coefficient set j: corrector, short half-band, long half-band
  for (genvar j = 0; j < NFIR; j++) begin : g_fir
    dcf_fir_dec2 #(
      .KIND (j),
      .DW   (DW)
    ) u_fir (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (s_vld[j]),
      .in_data  (s_data[j]),
      .out_vld  (s_vld[j+1]),
      .out_data (s_data[j+1])
    );
  end

  dcf_out_round #(
    .IW (DW),
    .OW (OUT_W),
    .SH (OSH)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (s_vld[NFIR]),
    .in_data  (s_data[NFIR]),
    .out_vld  (out_valid),
    .out_data (out_data)
  );
endmodule

// File: rtl/dcf_decim256_chk.sv
`timescale 1ns/1ps
module dcf_decim256_chk #(
  parameter int CIC_RATE  = 32,
  parameter int OUT_W     = 24,
  parameter int DEC_TOTAL = 256,
  parameter int QUIET     = 1024
) (
  input logic             clk,
  input logic             rst,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data,
  input logic             cic_vld,
  input logic             comp_vld
);
  logic [15:0] gap_cic, gap_cmp, gap_out, since_rst;
  logic        seen_cic, seen_cmp, seen_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cic   <= '0;
      gap_cmp   <= '0;
      gap_out   <= '0;
      since_rst <= '0;
      seen_cic  <= 1'b0;
      seen_cmp  <= 1'b0;
      seen_out  <= 1'b0;
    end else begin
      gap_cic  <= cic_vld   ? 16'd0 : gap_cic + 16'd1;
      gap_cmp  <= comp_vld  ? 16'd0 : gap_cmp + 16'd1;
      gap_out  <= out_valid ? 16'd0 : gap_out + 16'd1;
      seen_cic <= seen_cic | cic_vld;
      seen_cmp <= seen_cmp | comp_vld;
      seen_out <= seen_out | out_valid;
      if (since_rst != 16'(QUIET)) since_rst <= since_rst + 16'd1;
    end
  end

  AST_CIC_SPACING: assert property (@(posedge clk) disable iff (rst)
    (cic_vld && seen_cic) |-> (gap_cic == 16'(CIC_RATE - 1))); // R2
  AST_COMP_SPACING: assert property (@(posedge clk) disable iff (rst)
    (comp_vld && seen_cmp) |-> (gap_cmp == 16'(2 * CIC_RATE - 1))); // R2
  AST_OUT_SPACING: assert property (@(posedge clk) disable iff (rst)
    (out_valid && seen_out) |-> (gap_out == 16'(DEC_TOTAL - 1))); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data)); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0)); // R7
  AST_LATE_START: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (since_rst == 16'(QUIET))); // R7
endmodule

bind dcf_decim256 dcf_decim256_chk #(
  .CIC_RATE (CIC_RATE),
  .OUT_W    (OUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_data  (out_data),
  .cic_vld   (s_vld[0]),
  .comp_vld  (s_vld[1])
);

// File: tb/test_dcf_decim256.sv
`timescale 1ns/1ps
module test_dcf_decim256;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_bit = 1'b0;
  logic out_valid;
  logic signed [23:0] out_data;

  int n_chk = 0;
  int n_err = 0;
  longint cyc = 0;
  longint last_cyc = 0;
  logic [15:0] pat = 16'h0001;
  int plen = 1;
  int pidx = 0;

  localparam longint MAXP = 8388607;
  localparam longint MAXN = -8388608;

  always #2 clk = ~clk;

  dcf_decim256 i_dcf_decim256 (
    .clk       (clk),
    .rst       (rst),
    .mod_bit   (mod_bit),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    mod_bit <= pat[pidx];
    pidx    <= (pidx + 1 >= plen) ? 0 : pidx + 1;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!out_valid);
    last_cyc = cyc;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 valid low in reset", longint'(out_valid), 0);
    chk("R7 data zero in reset", longint'(out_data), 0);
    rst = 1'b0;
  endtask

  task automatic set_pat(input logic [15:0] p, input int len);
    pat  = p;
    plen = len;
  endtask

  task automatic t_reset_quiet();
    longint start;
    set_pat(16'h0001, 1);
    do_reset();
    start = cyc;
    wait_valid();
    chk("R7 first strobe after 1024 clocks", longint'((cyc - start) >= 1024), 1);
  endtask

  task automatic t_level(input string req, input logic [15:0] p, input int len,
                         input longint exp);
    set_pat(p, len);
    do_reset();
    repeat (12) wait_valid();
    for (int i = 0; i < 3; i++) begin
      wait_valid();
      chk(req, longint'(out_data), exp);
    end
  endtask

  task automatic t_rate();
    longint prev;
    logic signed [23:0] held;
    set_pat(16'h0007, 4);
    do_reset();
    repeat (12) wait_valid();
    for (int i = 0; i < 5; i++) begin
      prev = last_cyc;
      wait_valid();
      chk("R2 strobe spacing", last_cyc - prev, 256);
      held = out_data;
      @(negedge clk);
      chk("R3 strobe one clock wide", longint'(out_valid), 0);
      repeat (100) @(negedge clk);
      chk("R3 data held between strobes", longint'(out_data), longint'(held));
    end
  endtask

  task automatic t_step();
    set_pat(16'h0001, 1);
    do_reset();
    repeat (14) wait_valid();
    chk("R8 before step", longint'(out_data), MAXP);
    set_pat(16'h0000, 1);
    repeat (16) wait_valid();
    chk("R8 after step", longint'(out_data), MAXN);
  endtask

  initial begin
    #480000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements): actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset_quiet();
    t_level("R1 R6 all ones clamps to max", 16'h0001, 1, MAXP);
    t_level("R1 all zeros gives min", 16'h0000, 1, MAXN);
    t_level("R5 pattern 10 gives zero", 16'h0001, 2, 0);
    t_level("R5 pattern 1100 gives zero", 16'h0003, 4, 0);
    t_level("R5 pattern 11110000 gives zero", 16'h000F, 8, 0);
    t_level("R4 pattern 1110 gives half scale", 16'h0007, 4, 4194304);
    t_level("R4 pattern 1000 gives negative half", 16'h0001, 4, -4194304);
    t_rate();
    t_step();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule